// File: doc/BRIEF.md
# Shared Two-Thread Instruction Decoder

This block is the decode stage of a processor front end that two hardware threads share. Each thread owns a small queue of instruction descriptors. Fetch fills these queues, and decode drains them at its own pace. A descriptor has already been classified upstream. It carries:

- an instruction kind: plain, two-op or sequenced;
- a prefix count;
- a compare flag and a conditional-branch flag;
- a sequence length;
- a tag that identifies the instruction further down the pipe.

In every cycle the decoder works for one thread only. It turns that thread's oldest descriptors into macro-ops and presents them on a single output bundle. The bundle is registered, carries the thread number, and uses a valid/ready handshake.

The decoder applies several throughput rules:

- **Pairing.** Two plain instructions may leave together in one cycle. A two-op instruction occupies the whole cycle.
- **Fusion.** A compare directly followed by a conditional branch leaves as one fused macro-op.
- **Prefix stalls.** A long prefix string holds the decoder for a fixed number of extra cycles.
- **Sequenced instructions.** The decoder issues these one macro-op per cycle. Until the last one leaves, no other instruction from either thread is decoded.

A counter stands in for the microcode sequencer.

Top module: `dual_thread_decoder`

## Requirements
- R1: When both queues hold work, the decoder serves the thread opposite to the one it last issued for. After reset, thread 0 is served first.
- R2: If the thread whose turn it is has an empty queue, the other thread is served in that cycle instead of leaving the decoder idle.
- R3: Kind encoding on `push_kind` is 0 = plain (one macro-op), 1 = two-op, 2 or 3 = sequenced.
  - Two plain heads with prefix counts of 3 or less leave together: `out_count`=2, with `out_tag0`/`out_tag1` holding the older and the younger tag.
  - A two-op head leaves alone with `out_count`=2 and both tags equal.
  - A plain head with no eligible partner leaves with `out_count`=1.
- R4: A plain head with its compare flag set, directly followed in the same queue by a plain branch-flagged instruction with at most 3 prefixes, leaves as one output. That output has `out_count`=1 and `out_fused`=1, with `out_tag1` holding the branch's tag.
- R5: Fusion needs both instructions in the queue in the same cycle. A compare whose branch has not yet arrived leaves alone, unfused.
- R6: A sequenced instruction with length L produces L outputs on consecutive accepted cycles. Each has `out_count`=1, `out_ucode`=1 and the instruction's tag. Nothing from either thread is decoded until the last of them has been issued.
- R7: Prefix count decides decode latency:
  - 0–3 prefixes add no delay.
  - 4–7 prefixes add 14 cycles.
  - 8–11 prefixes make decode take 21 cycles in total, 20 more than normal.
- R8: A prefix count above 11 is issued at once, with `out_illegal`=1 and `out_count`=1, and the descriptor is consumed.
- R9: While `out_valid` is high and `out_ready` low, the output bundle stays unchanged and no decode progress is made.
- R10: `push_ready` of a thread is high while its queue holds fewer than DEPTH (default 8) descriptors. A thread's accepted descriptors are decoded in push order.
- R11: After reset, `out_valid` is low and both `push_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 2 | Per-thread descriptor offer |
| push_ready | output | 2 | Per-thread queue has room |
| push_kind | input | 4 | Per-thread kind, 2 bits each |
| push_pfx | input | 8 | Per-thread prefix count, 4 bits each |
| push_cmp | input | 2 | Per-thread compare flag |
| push_jcc | input | 2 | Per-thread conditional-branch flag |
| push_ulen | input | 10 | Per-thread sequence length, 5 bits each |
| push_tag | input | 16 | Per-thread instruction tag, 8 bits each |
| out_valid | output | 1 | Output bundle holds macro-ops |
| out_ready | input | 1 | Consumer accepts the bundle |
| out_thread | output | 1 | Thread the bundle belongs to |
| out_count | output | 2 | Number of macro-ops (1 or 2) |
| out_tag0 | output | 8 | Tag of the first macro-op |
| out_tag1 | output | 8 | Tag of the second macro-op, or of the fused branch |
| out_fused | output | 1 | Compare and branch fused |
| out_ucode | output | 1 | Op comes from the sequencer stand-in |
| out_illegal | output | 1 | Prefix count out of range |

## Verification
The assertions check the following on every cycle:

- the turn rule and the empty-queue skip of the thread choice;
- the absence of queue pops while a sequence is running or a prefix stall is counting;
- the shape of fused and illegal bundles;
- that the bundle is held under backpressure.

Only the bench scenarios can show which instructions pair, that fusion depends on arrival order, the exact extra latency at each prefix boundary (3/4, 7/8, 11/12), and that a sequenced instruction delays the other thread's work. A scoreboard compares every accepted bundle against the order the requirements predict.

// File: rtl/decode_pkg.sv
`timescale 1ns/1ps
package decode_pkg;
    localparam int NUM_THREADS  = 2;
    localparam int TAG_W        = 8;
    localparam int PFX_W        = 4;
    localparam int ULEN_W       = 5;
    localparam int KIND_W       = 2;
    localparam int PFX_FAST_MAX = 3;
    localparam int PFX_MID_MAX  = 7;
    localparam int PFX_HI_MAX   = 11;
    localparam int MID_EXTRA    = 14;
    localparam int HI_TOTAL     = 21;
    localparam int HI_EXTRA     = HI_TOTAL - 1;
    localparam int STALL_W      = $clog2(HI_EXTRA + 1);

    typedef enum logic [KIND_W-1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_TWO    = 2'd1,
        KIND_SEQ    = 2'd2,
        KIND_SEQ_X  = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [PFX_W-1:0]   pfx;
        logic               cmp;
        logic               jcc;
        logic [ULEN_W-1:0]  ulen;
        logic [TAG_W-1:0]   tag;
    } desc_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STALL,
        ACT_ILLEGAL,
        ACT_SINGLE,
        ACT_PAIR,
        ACT_FUSE,
        ACT_TWO,
        ACT_SEQ
    } act_e;

    // Counter reload for a prefix stall; the decode cycle itself is the +1.
    function automatic logic [STALL_W-1:0] stall_reload(input logic [PFX_W-1:0] pfx);
        if (pfx <= PFX_W'(PFX_MID_MAX))
            return STALL_W'(MID_EXTRA - 1);
        else
            return STALL_W'(HI_EXTRA - 1);
    endfunction
endpackage

// File: rtl/thread_fifo.sv
`timescale 1ns/1ps
module thread_fifo import decode_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_valid,
    output logic       push_ready,
    input  desc_t      push_desc,
    input  logic [1:0] pop_n,
    output desc_t      head0,
    output desc_t      head1,
    output logic       valid0,
    output logic       valid1
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    desc_t           mem [DEPTH];
    logic [AW-1:0]   rd_q, wr_q;
    logic [CW-1:0]   cnt_q;
    logic            do_push;

    assign push_ready = cnt_q < CW'(DEPTH);
    assign do_push    = push_valid && push_ready;
    assign head0      = mem[rd_q];
    assign head1      = mem[rd_q + AW'(1)];
    assign valid0     = cnt_q != '0;
    assign valid1     = cnt_q > CW'(1);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + AW'(1);
            rd_q  <= rd_q + AW'(pop_n);
            cnt_q <= cnt_q + CW'(do_push) - CW'(pop_n);
        end
    end

    AST_POP_WITHIN: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= cnt_q);                                   // R10
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));                                   // R10
endmodule

// File: rtl/thread_pick.sv
`timescale 1ns/1ps
module thread_pick import decode_pkg::*; (
    input  logic                   turn,
    input  logic [NUM_THREADS-1:0] has_work,
    output logic                   sel,
    output logic                   any
);
    assign any = |has_work;
    assign sel = has_work[turn] ? turn : ~turn;
endmodule

// File: rtl/slot_decode.sv
`timescale 1ns/1ps
module slot_decode import decode_pkg::*; (
    input  logic               en,
    input  logic               bypass,
    input  kind_e              h0_kind,
    input  logic [PFX_W-1:0]   h0_pfx,
    input  logic               h0_cmp,
    input  logic               h1_valid,
    input  kind_e              h1_kind,
    input  logic [PFX_W-1:0]   h1_pfx,
    input  logic               h1_jcc,
    output act_e               act,
    output logic [1:0]         pop_n,
    output logic [STALL_W-1:0] stall_load
);
    logic h1_ok;

    assign h1_ok = h1_valid && (h1_kind == KIND_PLAIN) && (h1_pfx <= PFX_W'(PFX_FAST_MAX));

    always_comb begin
        act        = ACT_NONE;
        pop_n      = 2'd0;
        stall_load = stall_reload(h0_pfx);
        if (en) begin
            if (h0_pfx > PFX_W'(PFX_HI_MAX)) begin
                act   = ACT_ILLEGAL;
                pop_n = 2'd1;
            end else if (!bypass && h0_pfx > PFX_W'(PFX_FAST_MAX)) begin
                act = ACT_STALL;
            end else begin
                unique case (h0_kind)
                    KIND_PLAIN: begin
                        if (h1_ok && h0_cmp && h1_jcc) begin
                            act   = ACT_FUSE;
                            pop_n = 2'd2;
                        end else if (h1_ok) begin
                            act   = ACT_PAIR;
                            pop_n = 2'd2;
                        end else begin
                            act   = ACT_SINGLE;
                            pop_n = 2'd1;
                        end
                    end
                    KIND_TWO: begin
                        act   = ACT_TWO;
                        pop_n = 2'd1;
                    end
                    default: begin
                        act   = ACT_SEQ;
                        pop_n = 2'd1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_thread_decoder.sv
`timescale 1ns/1ps
module dual_thread_decoder import decode_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_THREADS-1:0]        push_valid,
    output logic [NUM_THREADS-1:0]        push_ready,
    input  logic [KIND_W*NUM_THREADS-1:0] push_kind,
    input  logic [PFX_W*NUM_THREADS-1:0]  push_pfx,
    input  logic [NUM_THREADS-1:0]        push_cmp,
    input  logic [NUM_THREADS-1:0]        push_jcc,
    input  logic [ULEN_W*NUM_THREADS-1:0] push_ulen,
    input  logic [TAG_W*NUM_THREADS-1:0]  push_tag,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic                          out_thread,
    output logic [1:0]                    out_count,
    output logic [TAG_W-1:0]              out_tag0,
    output logic [TAG_W-1:0]              out_tag1,
    output logic                          out_fused,
    output logic                          out_ucode,
    output logic                          out_illegal
);
    desc_t                  hd0 [NUM_THREADS];
    desc_t                  hd1 [NUM_THREADS];
    logic [NUM_THREADS-1:0] v0, v1;
    logic [1:0]             pop_n [NUM_THREADS];

    logic                   turn_q;
    logic                   seq_act_q;
    logic [ULEN_W-1:0]      seq_left_q;
    logic                   seq_thr_q;
    logic [TAG_W-1:0]       seq_tag_q;
    logic                   st_act_q;
    logic [STALL_W-1:0]     st_cnt_q;
    logic                   st_thr_q;

    logic                   can_issue, pick_sel, pick_any, cur, dec_en;
    act_e                   act;
    logic [1:0]             dec_pop;
    logic [STALL_W-1:0]     st_load;
    desc_t                  h0, h1;

    assign can_issue = !out_valid || out_ready;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        desc_t pd;
        always_comb begin
            pd.kind = kind_e'(push_kind[KIND_W*t +: KIND_W]);
            pd.pfx  = push_pfx[PFX_W*t +: PFX_W];
            pd.cmp  = push_cmp[t];
            pd.jcc  = push_jcc[t];
            pd.ulen = push_ulen[ULEN_W*t +: ULEN_W];
            pd.tag  = push_tag[TAG_W*t +: TAG_W];
        end
        assign pop_n[t] = (can_issue && cur == 1'(t)) ? dec_pop : 2'd0;
        thread_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_valid (push_valid[t]),
            .push_ready (push_ready[t]),
            .push_desc  (pd),
            .pop_n      (pop_n[t]),
            .head0      (hd0[t]),
            .head1      (hd1[t]),
            .valid0     (v0[t]),
            .valid1     (v1[t])
        );
    end

    thread_pick u_pick (
        .turn     (turn_q),
        .has_work (v0),
        .sel      (pick_sel),
        .any      (pick_any)
    );

    assign cur    = st_act_q ? st_thr_q : pick_sel;
    assign h0     = hd0[cur];
    assign h1     = hd1[cur];
    assign dec_en = !seq_act_q && (st_act_q ? (st_cnt_q == '0) : pick_any);

    slot_decode u_dec (
        .en         (dec_en),
        .bypass     (st_act_q),
        .h0_kind    (h0.kind),
        .h0_pfx     (h0.pfx),
        .h0_cmp     (h0.cmp),
        .h1_valid   (v1[cur]),
        .h1_kind    (h1.kind),
        .h1_pfx     (h1.pfx),
        .h1_jcc     (h1.jcc),
        .act        (act),
        .pop_n      (dec_pop),
        .stall_load (st_load)
    );

    logic unused_fields;
    assign unused_fields = ^{h0.jcc, h1.cmp, h1.ulen};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_thread  <= 1'b0;
            out_count   <= 2'd0;
            out_tag0    <= '0;
            out_tag1    <= '0;
            out_fused   <= 1'b0;
            out_ucode   <= 1'b0;
            out_illegal <= 1'b0;
            turn_q      <= 1'b0;
            seq_act_q   <= 1'b0;
            seq_left_q  <= '0;
            seq_thr_q   <= 1'b0;
            seq_tag_q   <= '0;
            st_act_q    <= 1'b0;
            st_cnt_q    <= '0;
            st_thr_q    <= 1'b0;
        end else if (can_issue) begin
            out_valid   <= 1'b0;
            out_fused   <= 1'b0;
            out_ucode   <= 1'b0;
            out_illegal <= 1'b0;
            if (seq_act_q) begin
                out_valid  <= 1'b1;
                out_thread <= seq_thr_q;
                out_count  <= 2'd1;
                out_tag0   <= seq_tag_q;
                out_tag1   <= seq_tag_q;
                out_ucode  <= 1'b1;
                seq_left_q <= seq_left_q - 1'b1;
                if (seq_left_q == ULEN_W'(1)) seq_act_q <= 1'b0;
            end else if (st_act_q && st_cnt_q != '0) begin
                st_cnt_q <= st_cnt_q - 1'b1;
            end else begin
                case (act)
                    ACT_NONE: ;
                    ACT_STALL: begin
                        st_act_q <= 1'b1;
                        st_cnt_q <= st_load;
                        st_thr_q <= cur;
                    end
                    default: begin
                        out_valid   <= 1'b1;
                        out_thread  <= cur;
                        out_tag0    <= h0.tag;
                        out_tag1    <= (act == ACT_PAIR || act == ACT_FUSE) ? h1.tag : h0.tag;
                        out_count   <= (act == ACT_PAIR || act == ACT_TWO) ? 2'd2 : 2'd1;
                        out_fused   <= (act == ACT_FUSE);
                        out_illegal <= (act == ACT_ILLEGAL);
                        out_ucode   <= (act == ACT_SEQ);
                        turn_q      <= ~cur;
                        st_act_q    <= 1'b0;
                        if (act == ACT_SEQ && h0.ulen > ULEN_W'(1)) begin
                            seq_act_q  <= 1'b1;
                            seq_left_q <= h0.ulen - 1'b1;
                            seq_thr_q  <= cur;
                            seq_tag_q  <= h0.tag;
                        end
                    end
                endcase
            end
        end
    end

    AST_TURN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!st_act_q && !seq_act_q && v0 == 2'b11) |-> (cur == turn_q));          // R1
    AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (!st_act_q && pick_any) |-> v0[cur]);                                   // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_count == 2'd1 || out_count == 2'd2));                // R3
    AST_FUSE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fused) |-> (out_count == 2'd1 && !out_ucode));         // R4
    AST_SEQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        seq_act_q |-> (pop_n[0] == 2'd0 && pop_n[1] == 2'd0));                  // R6
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_act_q && st_cnt_q != '0 && can_issue) |=> !out_valid);              // R7
    AST_STALL_NOPOP: assert property (@(posedge clk) disable iff (rst)
        (st_act_q && st_cnt_q != '0) |-> (pop_n[0] == 2'd0 && pop_n[1] == 2'd0)); // R7
    AST_ILLEGAL_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_count == 2'd1 && !out_fused));       // R8
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag0) && $stable(out_tag1)
                                       && $stable(out_thread) && $stable(out_count))); // R9
endmodule

// File: tb/test_dual_thread_decoder.sv
`timescale 1ns/1ps
module test_dual_thread_decoder;
    import decode_pkg::*;

    logic                          clk = 1'b0;
    logic                          rst;
    logic [NUM_THREADS-1:0]        push_valid;
    logic [NUM_THREADS-1:0]        push_ready;
    logic [KIND_W*NUM_THREADS-1:0] push_kind;
    logic [PFX_W*NUM_THREADS-1:0]  push_pfx;
    logic [NUM_THREADS-1:0]        push_cmp;
    logic [NUM_THREADS-1:0]        push_jcc;
    logic [ULEN_W*NUM_THREADS-1:0] push_ulen;
    logic [TAG_W*NUM_THREADS-1:0]  push_tag;
    logic                          out_valid, out_ready, out_thread;
    logic [1:0]                    out_count;
    logic [TAG_W-1:0]              out_tag0, out_tag1;
    logic                          out_fused, out_ucode, out_illegal;

    always #2.5 clk = ~clk;

    dual_thread_decoder i_dual_thread_decoder (
        .clk, .rst, .push_valid, .push_ready, .push_kind, .push_pfx, .push_cmp,
        .push_jcc, .push_ulen, .push_tag, .out_valid, .out_ready, .out_thread,
        .out_count, .out_tag0, .out_tag1, .out_fused, .out_ucode, .out_illegal
    );

    typedef struct {
        int    th;
        int    cnt;
        int    t0;
        int    t1;
        bit    fused;
        bit    uc;
        bit    ill;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int actv, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
        end
    endtask

    task automatic expect_op(input int th, input int cnt, input int t0, input int t1,
                             input bit fu, input bit uc, input bit il, input string req);
        exp_t e;
        e.th = th; e.cnt = cnt; e.t0 = t0; e.t1 = t1;
        e.fused = fu; e.uc = uc; e.ill = il; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic set_lane(input int th, input int kind, input int pfx, input bit cmp,
                            input bit jcc, input int ulen, input int tag);
        push_valid[th]                 = 1'b1;
        push_kind[KIND_W*th +: KIND_W] = KIND_W'(kind);
        push_pfx[PFX_W*th +: PFX_W]    = PFX_W'(pfx);
        push_cmp[th]                   = cmp;
        push_jcc[th]                   = jcc;
        push_ulen[ULEN_W*th +: ULEN_W] = ULEN_W'(ulen);
        push_tag[TAG_W*th +: TAG_W]    = TAG_W'(tag);
    endtask

    task automatic step();
        @(negedge clk);
        push_valid = '0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, req, "outputs still missing", exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    // Push one plain thread-0 instruction and count negedges until it appears.
    task automatic measure(input int pfx, input int tag, output int n);
        expect_op(0, 1, tag, tag, 1'b0, 1'b0, pfx > 11, pfx > 11 ? "R8" : "R7");
        set_lane(0, 0, pfx, 1'b0, 1'b0, 0, tag);
        @(negedge clk);
        push_valid = '0;
        n = 1;
        while (!out_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        drain(pfx > 11 ? "R8" : "R7");
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected output tag", out_tag0, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_thread == e.th[0], e.req, "thread", out_thread, e.th);
                    check(out_count == 2'(e.cnt), e.req, "count", out_count, e.cnt);
                    check(out_tag0 == TAG_W'(e.t0), e.req, "tag0", out_tag0, e.t0);
                    if (e.cnt == 2 || e.fused)
                        check(out_tag1 == TAG_W'(e.t1), e.req, "tag1", out_tag1, e.t1);
                    check(out_fused == e.fused, e.req, "fused", out_fused, e.fused);
                    check(out_ucode == e.uc, e.req, "ucode", out_ucode, e.uc);
                    check(out_illegal == e.ill, e.req, "illegal", out_illegal, e.ill);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base, n;
        rst = 1'b1;
        push_valid = '0; push_kind = '0; push_pfx = '0; push_cmp = '0;
        push_jcc = '0; push_ulen = '0; push_tag = '0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
        check(push_ready == 2'b11, "R11", "push_ready after reset", push_ready, 3);

        // Sequenced blocker on thread 1, then mixed work on both threads (R6, R1, R3, R4)
        for (int i = 0; i < 12; i++) expect_op(1, 1, 'hB0, 'hB0, 0, 1, 0, "R6");
        expect_op(0, 2, 'h10, 'h11, 0, 0, 0, "R3");
        expect_op(1, 2, 'h20, 'h20, 0, 0, 0, "R3");
        expect_op(0, 2, 'h12, 'h12, 0, 0, 0, "R1");
        expect_op(1, 2, 'h21, 'h22, 0, 0, 0, "R1");
        expect_op(0, 1, 'h13, 'h14, 1, 0, 0, "R4");
        expect_op(1, 2, 'h23, 'h24, 0, 0, 0, "R4");
        expect_op(0, 1, 'h15, 'h15, 0, 0, 0, "R2");
        set_lane(1, 2, 0, 0, 0, 12, 'hB0); step();
        set_lane(0, 0, 0, 0, 0, 0, 'h10); set_lane(1, 1, 0, 0, 0, 0, 'h20); step();
        set_lane(0, 0, 1, 0, 1, 0, 'h11); set_lane(1, 0, 0, 0, 0, 0, 'h21); step();
        set_lane(0, 1, 0, 0, 0, 0, 'h12); set_lane(1, 0, 2, 0, 0, 0, 'h22); step();
        set_lane(0, 0, 0, 1, 0, 0, 'h13); set_lane(1, 0, 0, 1, 0, 0, 'h23); step();
        set_lane(0, 0, 0, 0, 1, 0, 'h14); set_lane(1, 0, 3, 0, 0, 0, 'h24); step();
        set_lane(0, 0, 0, 0, 0, 0, 'h15); step();
        drain("R6");

        // R5: branch arrives after the compare already left
        expect_op(0, 1, 'h40, 'h40, 0, 0, 0, "R5");
        expect_op(0, 1, 'h41, 'h41, 0, 0, 0, "R5");
        set_lane(0, 0, 0, 1, 0, 0, 'h40); step();
        repeat (4) @(negedge clk);
        set_lane(0, 0, 0, 0, 1, 0, 'h41); step();
        drain("R5");

        // R7 / R8: prefix latency at every boundary
        measure(3, 'h50, base);
        measure(0, 'h51, n);  check(n == base,      "R7", "latency pfx0",  n, base);
        measure(4, 'h52, n);  check(n == base + 14, "R7", "latency pfx4",  n, base + 14);
        measure(7, 'h53, n);  check(n == base + 14, "R7", "latency pfx7",  n, base + 14);
        measure(8, 'h54, n);  check(n == base + 20, "R7", "latency pfx8",  n, base + 20);
        measure(11, 'h55, n); check(n == base + 20, "R7", "latency pfx11", n, base + 20);
        measure(12, 'h56, n); check(n == base,      "R8", "latency pfx12", n, base);

        // R9 / R10: backpressure hold and full queue
        out_ready = 1'b0;
        expect_op(1, 2, 'h60, 'h60, 0, 0, 0, "R9");
        expect_op(0, 2, 'h70, 'h71, 0, 0, 0, "R10");
        expect_op(1, 2, 'h61, 'h61, 0, 0, 0, "R9");
        expect_op(0, 2, 'h72, 'h73, 0, 0, 0, "R10");
        expect_op(0, 2, 'h74, 'h75, 0, 0, 0, "R10");
        expect_op(0, 2, 'h76, 'h77, 0, 0, 0, "R10");
        set_lane(1, 1, 0, 0, 0, 0, 'h60); step();
        set_lane(1, 1, 0, 0, 0, 0, 'h61); step();
        for (int i = 0; i < 8; i++) begin
            set_lane(0, 0, 0, 0, 0, 0, 'h70 + i);
            step();
        end
        for (int i = 0; i < 3; i++) begin
            check(out_valid == 1'b1, "R9", "valid held", out_valid, 1);
            check(out_tag0 == 8'h60, "R9", "tag held", out_tag0, 'h60);
            @(negedge clk);
        end
        check(push_ready[0] == 1'b0, "R10", "full queue ready", push_ready[0], 0);
        check(push_ready[1] == 1'b1, "R10", "other queue ready", push_ready[1], 1);
        out_ready = 1'b1;
        drain("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule